// File: doc/BRIEF.md
# Machine status register with legalised writes

This block keeps the 32-bit machine status word of a processor hart and applies software updates to it. Only a fixed group of fields can be written. Everything else keeps its old value. Some written values are repaired before they are stored:
- an unsupported previous-privilege encoding is dropped;
- the floating-point state field is folded to either off or dirty;
- the summary bit is recomputed from the state fields.

When a write alters a field that affects address translation, the block raises a one-cycle request to flush the translation cache.

A second write port gives the supervisor view of the same register. A supervisor write merges the supervisor-visible bits into the current value, and the result then goes through the same legalising path as a machine write. A masked supervisor read view is always available on its own output. The hart's pipeline drives the enable and data of both ports, plus two flags that say whether supervisor mode and user mode exist. Writes are sampled on the rising clock edge, and the outputs show the new value from that edge onward.

Top module: `mstat_reg`

## Requirements
- R1: After reset `status_o` is 0x0000_1800 (previous-machine-privilege field at bits 12:11 holds 11, all else zero) and `flush_o` is 0.
- R2: A machine write (`m_we`=1) updates only bits 1, 3, 5, 7, 8, 12:11, 14:13, 17, 18 and 19 (mask 0x000E_79AA) from `m_wdata`. Every other bit keeps its old value, and bits 16:15 always read zero.
- R3: The previous-machine-privilege field (bits 12:11) keeps its old value when the incoming value is 10, when it is 01 while `has_smode`=0, or when it is 00 while `has_umode`=0. The other masked bits of that write are still stored.
- R4: After any write, a nonzero floating-point state field (bits 14:13) is stored as 11, so that field reads only 00 or 11.
- R5: Bit 31 (`status_o[31]` and `sd_o`) equals 1 exactly when bits 14:13 are 11 or bits 16:15 are 11.
- R6: `flush_o` is 1 for exactly the one cycle after a write edge at which the stored bits 19, 18, 17 or 12:11 changed. Otherwise it is 0.
- R7: A supervisor write (`s_we`=1, `m_we`=0) takes bits 0, 1, 4, 5, 8, 16:13, 18, 19 and 31 (mask 0x800D_E133) from `s_wdata` and the rest from the current value. It then applies the rules of R2 to R6 to that merged word.
- R8: `sstatus_o` always equals `status_o` AND 0x800D_E133.
- R9: When `m_we` and `s_we` are both 1 in the same cycle, only the machine write takes effect and `s_wdata` is ignored.
- R10: In a cycle with neither write enable, `status_o` holds and `flush_o` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| m_we | input | 1 | Machine-level write enable |
| m_wdata | input | 32 | Machine-level write value |
| s_we | input | 1 | Supervisor-view write enable |
| s_wdata | input | 32 | Supervisor-view write value |
| has_smode | input | 1 | Supervisor privilege mode is implemented |
| has_umode | input | 1 | User privilege mode is implemented |
| status_o | output | 32 | Current machine status word |
| sstatus_o | output | 32 | Supervisor-visible view of the status word |
| flush_o | output | 1 | One-cycle translation-cache flush request |
| sd_o | output | 1 | Summary-dirty bit |

## Verification
The machine and supervisor write ports can fire in the same cycle. The bench drives both enables at once with write values that differ in supervisor-visible bits. The scoreboard expects only the machine value, so any trace of `s_wdata` in the stored word, or in the flush decision, is a mismatch. A second overlap is a single write that both triggers a flush and hits a dropped privilege encoding. In that case the flush must follow the bits actually stored, not the bits offered.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
   localparam int unsigned SW = 32;

   localparam int unsigned B_UIE  = 0;
   localparam int unsigned B_SIE  = 1;
   localparam int unsigned B_UPIE = 4;
   localparam int unsigned B_MIE  = 3;
   localparam int unsigned B_SPIE = 5;
   localparam int unsigned B_MPIE = 7;
   localparam int unsigned B_SPP  = 8;
   localparam int unsigned B_MPP  = 11;
   localparam int unsigned B_FS   = 13;
   localparam int unsigned B_XS   = 15;
   localparam int unsigned B_MPRV = 17;
   localparam int unsigned B_SUM  = 18;
   localparam int unsigned B_MXR  = 19;
   localparam int unsigned B_SD   = 31;

   localparam logic [SW-1:0] M_WMASK  = 32'h000E_79AA;
   localparam logic [SW-1:0] S_MASK   = 32'h800D_E133;
   localparam logic [SW-1:0] FL_MASK  = 32'h000E_1800;

   typedef enum logic [1:0] {
      PRIV_U = 2'b00,
      PRIV_S = 2'b01,
      PRIV_R = 2'b10,
      PRIV_M = 2'b11
   } priv_e;
endpackage

// File: rtl/mstat_sview.sv
module mstat_sview
   import mstat_pkg::*;
#(
   parameter bit ENABLE = 1'b1
) (
   input  logic          s_we,
   input  logic [SW-1:0] s_wdata,
   input  logic [SW-1:0] cur,
   output logic          s_we_eff,
   output logic [SW-1:0] merged,
   output logic [SW-1:0] rview
);
   generate
      if (ENABLE) begin : g_on
         assign s_we_eff = s_we;
         assign merged   = (cur & ~S_MASK) | (s_wdata & S_MASK);
         assign rview    = cur & S_MASK;
      end else begin : g_off
         assign s_we_eff = 1'b0;
         assign merged   = cur;
         assign rview    = '0;
      end
   endgenerate
endmodule

// File: rtl/mstat_legal.sv
module mstat_legal
   import mstat_pkg::*;
(
   input  logic [SW-1:0] old_v,
   input  logic [SW-1:0] wr_v,
   input  logic          has_smode,
   input  logic          has_umode,
   output logic [SW-1:0] new_v,
   output logic          flush_req
);
   logic [1:0]    wpp;
   logic          drop_pp;
   logic [SW-1:0] mask;
   logic [SW-1:0] raw;

   always_comb begin
      wpp     = wr_v[B_MPP +: 2];
      drop_pp = (wpp == PRIV_R) ||
                (wpp == PRIV_S && !has_smode) ||
                (wpp == PRIV_U && !has_umode);
      mask    = M_WMASK;
      if (drop_pp) mask[B_MPP +: 2] = 2'b00;
      raw     = (old_v & ~mask) | (wr_v & mask);
      new_v   = raw;
      new_v[B_XS +: 2] = 2'b00;
      if (|raw[B_FS +: 2]) new_v[B_FS +: 2] = 2'b11;
      new_v[B_SD] = (new_v[B_FS +: 2] == 2'b11) || (new_v[B_XS +: 2] == 2'b11);
      flush_req = |((new_v ^ old_v) & FL_MASK);
   end
endmodule

// File: rtl/mstat_reg.sv
module mstat_reg
   import mstat_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter logic [1:0]  RESET_MPP = 2'b11,
   parameter bit          SVIEW_EN  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            m_we,
   input  logic [XLEN-1:0] m_wdata,
   input  logic            s_we,
   input  logic [XLEN-1:0] s_wdata,
   input  logic            has_smode,
   input  logic            has_umode,
   output logic [XLEN-1:0] status_o,
   output logic [XLEN-1:0] sstatus_o,
   output logic            flush_o,
   output logic            sd_o
);
   localparam logic [XLEN-1:0] RST_VAL = XLEN'(RESET_MPP) << B_MPP;

   initial begin
      a_elab_width : assert (XLEN == SW)
         else $error("mstat_reg: XLEN must be %0d", SW);
   end

   logic [XLEN-1:0] stat_q;
   logic            flush_q;
   logic            s_we_eff;
   logic [XLEN-1:0] s_merged;
   logic [XLEN-1:0] src_v;
   logic [XLEN-1:0] nxt_v;
   logic            nxt_flush;
   logic            we_any;

   mstat_sview #(.ENABLE(SVIEW_EN)) u_sview (
      .s_we     (s_we),
      .s_wdata  (s_wdata),
      .cur      (stat_q),
      .s_we_eff (s_we_eff),
      .merged   (s_merged),
      .rview    (sstatus_o)
   );

   // R9: machine port has priority over the supervisor port
   assign src_v  = m_we ? m_wdata : s_merged;
   assign we_any = m_we | s_we_eff;

   mstat_legal u_legal (
      .old_v     (stat_q),
      .wr_v      (src_v),
      .has_smode (has_smode),
      .has_umode (has_umode),
      .new_v     (nxt_v),
      .flush_req (nxt_flush)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q  <= RST_VAL;
         flush_q <= 1'b0;
      end else begin
         flush_q <= we_any & nxt_flush;
         if (we_any) stat_q <= nxt_v;
      end
   end

   assign status_o = stat_q;
   assign flush_o  = flush_q;
   assign sd_o     = stat_q[B_SD];

   a_r4_fs_two_state : assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[B_FS +: 2] == 2'b00) || (status_o[B_FS +: 2] == 2'b11));

   a_r3_no_reserved_pp : assert property (@(posedge clk) disable iff (!rst_n)
      status_o[B_MPP +: 2] != 2'b10);

   a_r5_xs_zero : assert property (@(posedge clk) disable iff (!rst_n)
      status_o[B_XS +: 2] == 2'b00);

   a_r6_flush_needs_write : assert property (@(posedge clk) disable iff (!rst_n)
      !(m_we || s_we) |=> !flush_o);

   a_r10_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !(m_we || s_we) |=> $stable(status_o));

   a_r8_sview : assert property (@(posedge clk) disable iff (!rst_n)
      SVIEW_EN |-> ((sstatus_o & ~S_MASK) == '0));
endmodule

// File: tb/mstat_reg_tb.sv
module mstat_reg_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        m_we, s_we, has_smode, has_umode;
   logic [31:0] m_wdata, s_wdata;
   logic [31:0] status_o, sstatus_o;
   logic        flush_o, sd_o;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   mstat_reg u_dut (
      .clk(clk), .rst_n(rst_n),
      .m_we(m_we), .m_wdata(m_wdata),
      .s_we(s_we), .s_wdata(s_wdata),
      .has_smode(has_smode), .has_umode(has_umode),
      .status_o(status_o), .sstatus_o(sstatus_o),
      .flush_o(flush_o), .sd_o(sd_o)
   );

   typedef struct {
      logic [31:0] st;
      logic        fl;
      string       tag;
   } exp_t;

   exp_t        q[$];
   logic [31:0] mdl;
   bit          done = 0;

   function automatic logic [32:0] ref_write(logic [31:0] o, logic [31:0] w,
                                             logic hs, logic hu);
      logic [31:0] m;
      logic [31:0] r;
      m = 32'h000E_79AA;
      if (w[12:11] == 2'b10 || (w[12:11] == 2'b01 && !hs) ||
          (w[12:11] == 2'b00 && !hu)) m[12:11] = 2'b00;
      r = (o & ~m) | (w & m);
      if (r[14:13] != 2'b00) r[14:13] = 2'b11;
      r[16:15] = 2'b00;
      r[31] = (r[14:13] == 2'b11);
      return {|((r ^ o) & 32'h000E_1800), r};
   endfunction

   task automatic check(string tag, logic [31:0] st, logic fl);
      checks++;
      if (status_o !== st || flush_o !== fl || sd_o !== st[31] ||
          sstatus_o !== (st & 32'h800D_E133)) begin
         fails++;
         $display("FAIL %s status=%h flush=%b sd=%b sview=%h exp status=%h flush=%b sd=%b sview=%h",
                  tag, status_o, flush_o, sd_o, sstatus_o, st, fl, st[31],
                  st & 32'h800D_E133);
      end
   endtask

   // driver: one call per cycle
   task automatic drive(string tag, logic mw, logic [31:0] md,
                        logic sw, logic [31:0] sd, logic hs, logic hu);
      logic [32:0] res;
      exp_t e;
      @(negedge clk);
      m_we = mw; m_wdata = md; s_we = sw; s_wdata = sd;
      has_smode = hs; has_umode = hu;
      if (mw)      res = ref_write(mdl, md, hs, hu);
      else if (sw) res = ref_write(mdl, (mdl & ~32'h800D_E133) | (sd & 32'h800D_E133), hs, hu);
      else         res = {1'b0, mdl};
      mdl   = res[31:0];
      e.st  = res[31:0];
      e.fl  = res[32];
      e.tag = tag;
      q.push_back(e);
   endtask

   // monitor
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         check(e.tag, e.st, e.fl);
      end
   end

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 0; m_we = 0; s_we = 0; m_wdata = 0; s_wdata = 0;
      has_smode = 1; has_umode = 1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      mdl = 32'h0000_1800;
      @(posedge clk); #1;
      check("R1 reset", 32'h0000_1800, 1'b0);

      drive("R2 all ones", 1, 32'hFFFF_FFFF, 0, 0, 1, 1);
      drive("R10 idle", 0, 32'h1234_5678, 0, 0, 1, 1);
      drive("R2 all zeros", 1, 32'h0000_0000, 0, 0, 1, 1);
      drive("R2 pattern", 1, 32'h5A5A_A5A5, 0, 0, 1, 1);
      drive("R4 FS 01", 1, 32'h0000_3800 & 32'hFFFF_DFFF | 32'h0000_2000, 0, 0, 1, 1);
      drive("R4 FS 10", 1, 32'h0000_5800, 0, 0, 1, 1);
      drive("R5 FS off", 1, 32'h0000_1800, 0, 0, 1, 1);
      drive("R3 reserved pp", 1, 32'h0000_1008 | 32'h0008_0000, 0, 0, 1, 1);
      drive("R3 S absent", 1, 32'h0000_0800, 0, 0, 0, 1);
      drive("R3 U absent", 1, 32'h0000_0000, 0, 0, 1, 0);
      drive("R3 S present", 1, 32'h0000_0800, 0, 0, 1, 1);
      drive("R6 no flush bits", 1, 32'h0000_08AA, 0, 0, 1, 1);
      drive("R6 same value", 1, 32'h0000_08AA, 0, 0, 1, 1);
      drive("R6 MPRV", 1, 32'h0002_08AA, 0, 0, 1, 1);
      drive("R10 idle after flush", 0, 0, 0, 0, 1, 1);
      drive("R7 sview all ones", 0, 0, 1, 32'hFFFF_FFFF, 1, 1);
      drive("R7 sview zeros", 0, 0, 1, 32'h0000_0000, 1, 1);
      drive("R7 sview SUM", 0, 0, 1, 32'h0004_0002, 1, 1);
      drive("R9 collision", 1, 32'h0000_0008, 1, 32'h800F_E133, 1, 1);
      drive("R9 collision b", 1, 32'h0008_6000, 1, 32'h0000_0000, 1, 1);
      for (int i = 0; i < 12; i++)
         drive("R2 sweep", i[0], 32'h9E37_79B9 * (i + 1), ~i[0], 32'h7F4A_7C15 * (i + 3),
               i[1], i[2] | i[0]);
      drive("R10 final idle", 0, 0, 0, 0, 1, 1);
      drive("R10 final idle", 0, 0, 0, 0, 1, 1);
      @(posedge clk); #2;
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule